// File: doc/BRIEF.md
# Two-Strobe Pulse Order Detector with Latched Flag

This block is a synchronous Moore machine that follows a stream of pulses on two single-cycle strobes, `x1` and `x2`. It raises its flag `z` once the pulses have come in the order x1, x1, x2, x2, x2, x1. The flag then stays high through any number of extra x1 pulses. The first x2 pulse after a detection clears it. Cycles with no strobe, and cycles in which both strobes are high together, do not move the machine.

On a mismatch the machine keeps the longest tail of the pulses seen so far that is still a valid start of the target order. Pulse streams that overlap a partial match are therefore not lost. When x2 clears a detection, the machine restarts from the beginning with no partial credit.

The target order is a parameter, and the fallback transitions are computed from it at elaboration. The default value gives the order above.

Top module: `pseq_hold_det`

## Requirements
- R1: While `rst_n` is low at a rising edge, the machine returns to its empty-match state, so `z` is 0 after that edge and no earlier pulse counts toward a later detection.
- R2: A cycle with neither strobe, or with both `x1` and `x2` high, leaves the match progress and `z` unchanged.
- R3: `z` goes to 1 after the clock edge at which the final x1 of the order x1 x1 x2 x2 x2 x1 is sampled, and not before.
- R4: While `z` is 1, each further x1 pulse keeps `z` at 1.
- R5: An x2 pulse while `z` is 1 sets `z` to 0 and empties the match. A following x1 x2 x2 x2 x1 therefore does not raise `z`.
- R6: An x1 that arrives after a two-x1 prefix keeps the two-x1 prefix, so x1 x1 x1 x2 x2 x2 x1 raises `z`.
- R7: An x1 that arrives after x1 x1 x2, or after x1 x1 x2 x2, leaves a one-x1 prefix, so a further x1 x2 x2 x2 x1 raises `z`.
- R8: An x2 that arrives after x1 x1 x2 x2 x2 empties the match, so x1 x1 x2 x2 x2 x2 x1 does not raise `z`.
- R9: `z` is a registered output. It changes only at a rising clock edge, as a function of the pulses sampled up to and including that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x1 | input | 1 | First pulse strobe, one cycle wide |
| x2 | input | 1 | Second pulse strobe, one cycle wide |
| z | output | 1 | Detection flag, held until cleared by x2 |

## Verification
The embedded assertions check on every cycle that:
- an idle or double strobe freezes the state;
- `z` can rise only after an x1;
- an x1 keeps `z` high and an x2 drops it to the empty state;
- `z` always agrees with the detected state.

The fallback targets for each kind of mismatch (R6, R7, R8), and the loss of credit after a clear, depend on the history of several pulses. Only the bench scenarios show these. The bench drives directed orderings for each of them and long random streams, and compares `z` on every clock with a model that keeps a queue of recent pulses.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
   localparam int unsigned PAT_MAX = 16;

   // symbol coding: 0 = x1 pulse, 1 = x2 pulse
   typedef enum logic {SYM_X1 = 1'b0, SYM_X2 = 1'b1} pseq_sym_e;

   // Longest prefix of pat that ends the string pat[0..k-1] followed by sym.
   function automatic int unsigned prefix_step(input logic [PAT_MAX-1:0] pat,
                                               input int unsigned k,
                                               input logic sym);
      int unsigned best;
      logic        ok;
      logic [PAT_MAX:0] cand;
      best = 0;
      cand = '0;
      for (int i = 0; i < PAT_MAX; i++) begin
         if (i < int'(k)) cand[i] = pat[i];
      end
      cand[k] = sym;
      for (int j = 1; j <= PAT_MAX; j++) begin
         if (j <= int'(k) + 1) begin
            ok = 1'b1;
            for (int i = 0; i < PAT_MAX; i++) begin
               if (i < j) begin
                  if (pat[i] != cand[int'(k) + 1 - j + i]) ok = 1'b0;
               end
            end
            if (ok) best = j;
         end
      end
      return best;
   endfunction
endpackage

// File: rtl/pseq_strobe_decode.sv
module pseq_strobe_decode
   import pseq_pkg::*;
(
   input  logic      x1,
   input  logic      x2,
   output logic      step_vld,
   output pseq_sym_e step_sym
);
   // exactly one strobe advances the machine; none or both is a no-op
   always_comb begin
      step_vld = x1 ^ x2;
      step_sym = x2 ? SYM_X2 : SYM_X1;
   end
endmodule

// File: rtl/pseq_next_table.sv
module pseq_next_table
   import pseq_pkg::*;
#(
   parameter int unsigned SEQ_LEN     = 6,
   parameter logic [SEQ_LEN-1:0] SEQ_PATTERN = 6'b011100,
   parameter int unsigned SW          = 3
)(
   input  logic [SW-1:0] cur,
   input  pseq_sym_e     sym,
   output logic [SW-1:0] nxt
);
   localparam int unsigned DET = SEQ_LEN;
   localparam logic [PAT_MAX-1:0] PAT_PAD = PAT_MAX'(SEQ_PATTERN);
   localparam logic HOLD_SYM = SEQ_PATTERN[SEQ_LEN-1];

   logic [SW-1:0] on_x1 [0:SEQ_LEN];
   logic [SW-1:0] on_x2 [0:SEQ_LEN];

   for (genvar k = 0; k < SEQ_LEN; k++) begin : g_row
      localparam int unsigned N1 = prefix_step(PAT_PAD, k, 1'b0);
      localparam int unsigned N2 = prefix_step(PAT_PAD, k, 1'b1);
      assign on_x1[k] = SW'(N1);
      assign on_x2[k] = SW'(N2);
   end

   // detected row: the final symbol of the order holds, the other clears
   if (HOLD_SYM == 1'b0) begin : g_hold_x1
      assign on_x1[DET] = SW'(DET);
      assign on_x2[DET] = '0;
   end else begin : g_hold_x2
      assign on_x1[DET] = '0;
      assign on_x2[DET] = SW'(DET);
   end

   always_comb begin
      nxt = '0;
      if (int'(cur) <= int'(DET)) begin
         nxt = (sym == SYM_X2) ? on_x2[cur] : on_x1[cur];
      end
   end

   // any legal state maps onto a legal state (R9 keeps z tied to states)
   always_comb begin
      if (int'(cur) <= int'(DET)) begin
         a_next_in_range_r9 : assert (int'(nxt) <= int'(DET));
      end
   end
endmodule

// File: rtl/pseq_hold_det.sv
module pseq_hold_det
   import pseq_pkg::*;
#(
   parameter int unsigned SEQ_LEN     = 6,
   parameter logic [SEQ_LEN-1:0] SEQ_PATTERN = 6'b011100,
   parameter bit          Z_FROM_NEXT = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic x1,
   input  logic x2,
   output logic z
);
   localparam int unsigned SW  = $clog2(SEQ_LEN + 1);
   localparam int unsigned DET = SEQ_LEN;
   localparam logic HOLD_SYM   = SEQ_PATTERN[SEQ_LEN-1];

   if (SEQ_LEN < 2 || SEQ_LEN > PAT_MAX - 1) begin : g_bad_len
      $error("pseq_hold_det: SEQ_LEN out of supported range");
   end

   logic          step_vld;
   pseq_sym_e     step_sym;
   logic [SW-1:0] state_q, state_tbl, state_nxt;

   pseq_strobe_decode u_dec (
      .x1       (x1),
      .x2       (x2),
      .step_vld (step_vld),
      .step_sym (step_sym)
   );

   pseq_next_table #(
      .SEQ_LEN     (SEQ_LEN),
      .SEQ_PATTERN (SEQ_PATTERN),
      .SW          (SW)
   ) u_tbl (
      .cur (state_q),
      .sym (step_sym),
      .nxt (state_tbl)
   );

   always_comb state_nxt = step_vld ? state_tbl : state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_nxt;
   end

   if (Z_FROM_NEXT) begin : g_z_flop
      logic z_q;
      always_ff @(posedge clk) begin
         if (!rst_n) z_q <= 1'b0;
         else        z_q <= (state_nxt == SW'(DET));
      end
      assign z = z_q;
   end else begin : g_z_decode
      assign z = (state_q == SW'(DET));
   end

   // ---------------- assertions ----------------
   p_idle_freeze_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !(x1 ^ x2) |=> $stable(state_q) && $stable(z));

   p_rise_on_last_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(z) |-> $past((x1 ^ x2) && (x2 == HOLD_SYM)));

   p_hold_flag_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      z && (x1 ^ x2) && (x2 == HOLD_SYM) |=> z);

   p_clear_flag_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      z && (x1 ^ x2) && (x2 != HOLD_SYM) |=> !z && (state_q == '0));

   p_z_tracks_state_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      z == (state_q == SW'(DET)));
endmodule

// File: tb/pseq_hold_det_tb_top.sv
`timescale 1ns/1ps
module pseq_hold_det_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic x1 = 1'b0;
   logic x2 = 1'b0;
   logic z;

   always #4 clk = ~clk;   // 125 MHz

   pseq_hold_det dut_i (.clk(clk), .rst_n(rst_n), .x1(x1), .x2(x2), .z(z));

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit hist[$];
   bit exp_z = 1'b0;
   bit pat [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};  // 0 = x1, 1 = x2

   // reference: history of pulses since the last clear
   task automatic model(bit a, bit b, bit r);
      bit s;
      bit hit;
      if (!r) begin
         hist.delete();
         exp_z = 1'b0;
      end else if (a ^ b) begin
         s = b;
         if (exp_z) begin
            if (s) begin
               exp_z = 1'b0;
               hist.delete();
            end
         end else begin
            hist.push_back(s);
            if (hist.size() > 6) void'(hist.pop_front());
            hit = (hist.size() == 6);
            for (int i = 0; i < 6; i++) begin
               if (hit && hist[i] != pat[i]) hit = 1'b0;
            end
            if (hit) begin
               exp_z = 1'b1;
               hist.delete();
            end
         end
      end
   endtask

   task automatic step(bit a, bit b, bit r, string tag);
      x1 = a; x2 = b; rst_n = r;
      model(a, b, r);
      @(negedge clk);
      n_vec++;
      if (z !== exp_z) begin
         n_bad++;
         $display("FAIL %s: z=%0b expected %0b at %0t", tag, z, exp_z, $time);
      end
   endtask

   // '1' = x1, '2' = x2, 'b' = both, '-' = none, 'r' = reset
   task automatic play(string s, string tag);
      for (int i = 0; i < s.len(); i++) begin
         case (s[i])
            "1":     step(1'b1, 1'b0, 1'b1, tag);
            "2":     step(1'b0, 1'b1, 1'b1, tag);
            "b":     step(1'b1, 1'b1, 1'b1, tag);
            "r":     step(1'b0, 1'b0, 1'b0, tag);
            default: step(1'b0, 1'b0, 1'b1, tag);
         endcase
      end
   endtask

   task automatic expect_z(bit v, string tag);
      n_vec++;
      if (z !== v) begin
         n_bad++;
         $display("FAIL %s: z=%0b expected %0b at %0t", tag, z, v, $time);
      end
   endtask

   initial begin
      @(negedge clk);
      play("rr", "R1 reset");
      expect_z(1'b0, "R1 reset");
      play("112221", "R3 detect");
      expect_z(1'b1, "R3 detect");
      play("1-11-1", "R4 hold");
      expect_z(1'b1, "R4 hold");
      play("2", "R5 clear");
      expect_z(1'b0, "R5 clear");
      play("12221", "R5 no credit");
      expect_z(1'b0, "R5 no credit");
      play("r", "R1 reset");
      play("11-b2-2b21", "R2 idle and both");
      expect_z(1'b1, "R2 idle and both");
      play("2r", "R1 reset");
      play("1112221", "R6 extra x1");
      expect_z(1'b1, "R6 extra x1");
      play("2r", "R1 reset");
      play("112112221", "R7 fallback after three");
      expect_z(1'b1, "R7 fallback after three");
      play("2r", "R1 reset");
      play("1122112221", "R7 fallback after four");
      expect_z(1'b1, "R7 fallback after four");
      play("2r", "R1 reset");
      play("1122221", "R8 x2 after five");
      expect_z(1'b0, "R8 x2 after five");
      play("r", "R1 reset");
      play("11222r1", "R1 reset mid-match");
      expect_z(1'b0, "R1 reset mid-match");
      play("r", "R1 reset");
      for (int n = 0; n < 6000; n++) begin
         int unsigned p;
         p = $urandom_range(0, 99);
         if (p < 45)      step(1'b1, 1'b0, 1'b1, "R9 random");
         else if (p < 85) step(1'b0, 1'b1, 1'b1, "R9 random");
         else if (p < 93) step(1'b0, 1'b0, 1'b1, "R9 random");
         else if (p < 99) step(1'b1, 1'b1, 1'b1, "R2 random");
         else             step(1'b0, 1'b0, 1'b0, "R1 random");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule